// File: doc/BRIEF.md
# SPI Master with Packed Packets

This block is the serial engine of an SPI master. One 32-bit transmit word is split into one, two or four packets of 8 or 16 bits. The packet held in the low bits of the word leaves the engine first. Each packet goes out most significant bit first or least significant bit first. The bits that come back on the input line are packed into a 32-bit receive word in the same order, starting from bits 7:0. The engine supports all four combinations of clock polarity and phase. A divider sets the serial clock period. A control input drives the chip-select level directly.

Transmit words enter through a valid/ready stream. The ready signal is the transmit-empty flag, so a second word waits while the first still sits in the holding register. Received words leave through a second valid/ready stream whose valid signal is the receive-full flag. If that word is not taken, the engine does not start the next word. This back-pressure can reach the transmit side, and no received word is ever overwritten. The enable, chip-select level and the clock, packet and bit-order settings are plain inputs. The settings are captured when a word starts.

Top module: `spi_pk_master`

## Requirements
- R1: After reset, transmit-empty is 1, receive-full is 0, the enable readback is 0, chip select is 1 and the serial clock is 0.
- R2: The enable readback follows the enable input one clock later. While the readback is 0, no word starts and the serial clock does not toggle.
- R3: The chip-select output equals the chip-select level input of the previous clock (0 selects, 1 deselects).
- R4: Bits per word come from the packet count code and the packet width. For 8-bit packets, code 0 gives 8 bits, code 1 gives 16 and codes 2 and 3 give 32. For 16-bit packets, code 0 gives 16 bits and every other code gives 32. The clock shows two edges per bit.
- R5: Serial bit k belongs to packet k/L, where L is the packet width. Packet p occupies word bits [p*L +: L]. Received bits land at the same positions, and receive-word bits above the transfer length read 0.
- R6: With lsb-first set, each packet is shifted bit 0 first. With it clear, each packet is shifted bit L-1 first.
- R7: When no word is in flight, the serial clock rests at the polarity setting. With phase 0, data is sampled on the leading edge and changes on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge. Each half period lasts divider+1 clocks.
- R8: tx_ready (transmit-empty) drops in the clock after a word is accepted. It rises again once that word has been loaded into the shifter.
- R9: rx_valid (receive-full) rises after the last bit of a word is captured. It falls after an rx_ready handshake, and rx_data holds steady while rx_valid waits.
- R10: While rx_valid is 1, no new word is loaded. A word still in the holding register stays there and keeps tx_ready at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_enable | input | 1 | Engine enable request |
| ctl_cs_level | input | 1 | Chip-select level request (0 selects) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 1 drives on the leading edge and samples on the trailing edge |
| cfg_lsb_first | input | 1 | Shift each packet bit 0 first |
| cfg_wide | input | 1 | 1 for 16-bit packets, 0 for 8-bit packets |
| cfg_pkt_cnt | input | 2 | Packet count code: 0 for one, 1 for two, 2 or 3 for four |
| cfg_div | input | DIV_W | Half period of the serial clock minus one, in clocks |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty, word accepted |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 32 | Received word |
| sts_enabled | output | 1 | Enable readback |
| sts_tx_empty | output | 1 | Transmit register empty flag |
| sts_rx_full | output | 1 | Receive register full flag |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds the block with DIV_W = 3, so the half period of the serial clock ranges from 1 to 8 clocks. Every divider value can then be exercised, including the one-clock half period where data changes on every clock, and a word stays short enough for dozens of random words with all packet codes, modes and bit orders. A slave model in the bench records the serial output and feeds its own bit sequence back. The received words check packet order, bit order and the zero fill of unused bits. Words left unread show that the back-pressure holds the next transmit word.

// File: rtl/spi_pk_pkg.sv
package spi_pk_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CNT_W  = IDX_W + 1;
  localparam int NB_IDX = 3;  // bit index width inside an 8-bit packet
  localparam int WB_IDX = 4;  // bit index width inside a 16-bit packet

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             lsb;
    logic             wide;
    logic [CNT_W-1:0] nbits;
  } xfer_cfg_t;

  // total serial bits of one word for a packet width and a count code
  function automatic logic [CNT_W-1:0] word_bits(input logic wide, input logic [1:0] cnt);
    logic [CNT_W-1:0] r;
    case (cnt)
      2'd0:    r = wide ? CNT_W'(16) : CNT_W'(8);
      2'd1:    r = wide ? CNT_W'(WORD_W) : CNT_W'(16);
      default: r = CNT_W'(WORD_W);
    endcase
    return r;
  endfunction

  // word bit position of serial bit k
  function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] k,
                                               input logic wide, input logic lsb);
    logic [IDX_W-1:0] r;
    if (wide)
      r = {k[IDX_W-1:WB_IDX], lsb ? k[WB_IDX-1:0] : ~k[WB_IDX-1:0]};
    else
      r = {k[IDX_W-1:NB_IDX], lsb ? k[NB_IDX-1:0] : ~k[NB_IDX-1:0]};
    return r;
  endfunction
endpackage

// File: rtl/spi_pk_divider.sv
module spi_pk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || tick)
      cnt_q <= div;
    else
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/spi_pk_regs.sv
module spi_pk_regs #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_cs_level,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              load,
  input  logic              done,
  input  logic [WORD_W-1:0] done_word,
  input  logic              rx_ready,
  output logic              tx_full,
  output logic [WORD_W-1:0] tx_word,
  output logic              rx_full,
  output logic [WORD_W-1:0] rx_word,
  output logic              en_q,
  output logic              cs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_word <= '0;
      rx_full <= 1'b0;
      rx_word <= '0;
      en_q    <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      en_q <= ctl_enable;
      cs_q <= ctl_cs_level;
      if (tx_valid && !tx_full) begin
        tx_full <= 1'b1;
        tx_word <= tx_data;
      end else if (load) begin
        tx_full <= 1'b0;
      end
      if (done) begin
        rx_full <= 1'b1;
        rx_word <= done_word;
      end else if (rx_ready && rx_full) begin
        rx_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_pk_shifter.sv
module spi_pk_shifter
  import spi_pk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              word_avail,
  input  logic              rx_full,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_pkt_cnt,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tick,
  input  logic              miso,
  output logic              load,
  output logic              run,
  output logic [DIV_W-1:0]  div_q,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy
);
  xfer_cfg_t         cfg_q;
  logic              run_q, done_q, half_q, sclk_q, mosi_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] txw_q, rxw_q;
  logic [IDX_W-1:0]  cur_pos, nxt_pos, first_pos;
  logic              last;

  assign busy      = run_q || done_q;
  assign load      = en && word_avail && !rx_full && !busy;
  assign cur_pos   = bit_pos(idx_q, cfg_q.wide, cfg_q.lsb);
  assign nxt_pos   = bit_pos(idx_q + 1'b1, cfg_q.wide, cfg_q.lsb);
  assign first_pos = bit_pos('0, cfg_wide, cfg_lsb_first);
  assign last      = ({1'b0, idx_q} == (cfg_q.nbits - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      div_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      half_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      idx_q  <= '0;
      txw_q  <= '0;
      rxw_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        cfg_q  <= '{cpol: cfg_cpol, cpha: cfg_cpha, lsb: cfg_lsb_first,
                    wide: cfg_wide, nbits: word_bits(cfg_wide, cfg_pkt_cnt)};
        div_q  <= cfg_div;
        txw_q  <= tx_word;
        rxw_q  <= '0;
        idx_q  <= '0;
        half_q <= 1'b0;
        run_q  <= 1'b1;
        sclk_q <= cfg_cpol;
        if (!cfg_cpha) mosi_q <= tx_word[first_pos];
      end else if (run_q && tick) begin
        sclk_q <= ~sclk_q;
        if (!half_q) begin
          // leading edge
          half_q <= 1'b1;
          if (!cfg_q.cpha) rxw_q[cur_pos] <= miso;
          else             mosi_q <= txw_q[cur_pos];
        end else begin
          // trailing edge
          half_q <= 1'b0;
          if (cfg_q.cpha) rxw_q[cur_pos] <= miso;
          if (last) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (!cfg_q.cpha) mosi_q <= txw_q[nxt_pos];
          end
        end
      end else if (!run_q) begin
        sclk_q <= cfg_cpol;
      end
    end
  end

  assign run     = run_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign rx_word = rxw_q;
endmodule

// File: rtl/spi_pk_master.sv
module spi_pk_master
  import spi_pk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              ctl_cs_level,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_pkt_cnt,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sts_enabled,
  output logic              sts_tx_empty,
  output logic              sts_rx_full,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  logic              tx_full, rx_full, load, done, en_q, cs_q, busy, run, tick;
  logic [WORD_W-1:0] tx_word, done_word;
  logic [DIV_W-1:0]  div_q;

  spi_pk_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_cs_level(ctl_cs_level),
    .tx_valid(tx_valid), .tx_data(tx_data), .load(load), .done(done),
    .done_word(done_word), .rx_ready(rx_ready), .tx_full(tx_full), .tx_word(tx_word),
    .rx_full(rx_full), .rx_word(rx_data), .en_q(en_q), .cs_q(cs_q)
  );

  spi_pk_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  spi_pk_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en_q), .word_avail(tx_full), .rx_full(rx_full),
    .tx_word(tx_word), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide), .cfg_pkt_cnt(cfg_pkt_cnt),
    .cfg_div(cfg_div), .tick(tick), .miso(spi_miso), .load(load), .run(run),
    .div_q(div_q), .sclk(spi_sclk), .mosi(spi_mosi), .done(done),
    .rx_word(done_word), .busy(busy)
  );

  assign tx_ready     = !tx_full;
  assign sts_tx_empty = !tx_full;
  assign rx_valid     = rx_full;
  assign sts_rx_full  = rx_full;
  assign sts_enabled  = en_q;
  assign spi_cs_n     = cs_q;
endmodule

// File: rtl/spi_pk_master_chk.sv
module spi_pk_master_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_cs_level,
  input logic              cfg_cpol,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              sts_enabled,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              busy
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  assert_cs_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> spi_cs_n == $past(ctl_cs_level));

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !sts_enabled && !busy |=> !busy);

  assert_sclk_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !busy && $past(!busy) |-> spi_sclk == $past(cfg_cpol));

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  assert_no_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_valid);
endmodule

bind spi_pk_master spi_pk_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_cs_level(ctl_cs_level), .cfg_cpol(cfg_cpol),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .sts_enabled(sts_enabled), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .busy(busy)
);

// File: tb/spi_pk_master_bench.sv
module spi_pk_master_bench;
  localparam int DIV_W = 3;

  logic clk = 0, rst_n = 0;
  logic ctl_enable = 0, ctl_cs_level = 1;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_wide = 0;
  logic [1:0] cfg_pkt_cnt = 0;
  logic [DIV_W-1:0] cfg_div = 0;
  logic tx_valid = 0, rx_ready = 0, spi_miso = 0;
  logic [31:0] tx_data = 0;
  logic tx_ready, rx_valid, sts_enabled, sts_tx_empty, sts_rx_full;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic [31:0] rx_data;

  always #2 clk = ~clk;

  spi_pk_master #(.DIV_W(DIV_W)) u_spi_pk_master (.*);

  int total = 0, bad = 0, cyc = 0;

  // slave model
  logic [63:0] sbits, mrec;
  int scnt, dcnt, edges, gmin, gmax, last_cyc;
  logic prev_sclk = 0, t_cpol = 0, t_cpha = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (spi_sclk !== prev_sclk) begin
      edges = edges + 1;
      if (edges > 1) begin
        if (cyc - last_cyc < gmin) gmin = cyc - last_cyc;
        if (cyc - last_cyc > gmax) gmax = cyc - last_cyc;
      end
      last_cyc = cyc;
      if ((spi_sclk != t_cpol) ^ t_cpha) begin
        mrec[scnt & 63] = spi_mosi;
        scnt = scnt + 1;
      end else begin
        spi_miso = sbits[dcnt & 63];
        dcnt = dcnt + 1;
      end
    end
    prev_sclk = spi_sclk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int exp_bits(input logic wide, input logic [1:0] cnt);
    int len = wide ? 16 : 8;
    int n = (cnt == 0) ? 1 : (cnt == 1) ? 2 : 4;
    return (n * len > 32) ? 32 : n * len;
  endfunction

  function automatic int exp_pos(input int k, input logic wide, input logic lsb);
    int len = wide ? 16 : 8;
    int j = k % len;
    return (k / len) * len + (lsb ? j : len - 1 - j);
  endfunction

  logic c_wide, c_lsb;
  logic [1:0] c_cnt;
  logic [DIV_W-1:0] c_div;

  task automatic prep(input logic cpol, input logic cpha, input logic lsb,
                      input logic wide, input logic [1:0] cnt, input logic [DIV_W-1:0] dv);
    @(negedge clk);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_wide = wide;
    cfg_pkt_cnt = cnt; cfg_div = dv;
    c_wide = wide; c_lsb = lsb; c_cnt = cnt; c_div = dv;
    repeat (3) @(negedge clk);
    t_cpol = cpol; t_cpha = cpha;
    sbits = {$urandom, $urandom};
    mrec = '0; scnt = 0; edges = 0; gmin = 1000; gmax = 0;
    if (!cpha) begin spi_miso = sbits[0]; dcnt = 1; end
    else dcnt = 0;
  endtask

  task automatic push(input logic [31:0] w, input bit expect_hold);
    tx_valid = 1; tx_data = w;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
    if (!expect_hold)
      check(!tx_ready, "R8", "ready after accept", tx_ready, 0);
  endtask

  task automatic finish(input logic [31:0] w, input bit pop);
    int n, t;
    logic [31:0] erx;
    logic [63:0] emo;
    t = 0;
    while (!rx_valid && t < 5000) begin @(negedge clk); t++; end
    check(rx_valid, "R9", "rx_valid after word", rx_valid, 1);
    n = exp_bits(c_wide, c_cnt);
    erx = '0; emo = '0;
    for (int k = 0; k < n; k++) begin
      erx[exp_pos(k, c_wide, c_lsb)] = sbits[k];
      emo[k] = w[exp_pos(k, c_wide, c_lsb)];
    end
    check(scnt == n && edges == 2 * n, "R4", "sample count / edges",
          {32'(scnt), 32'(edges)}, {32'(n), 32'(2 * n)});
    check(rx_data == erx, "R5 R6", "received word", rx_data, erx);
    check(mrec == emo, "R5 R6", "serial out bits", mrec, emo);
    check(gmin == int'(c_div) + 1 && gmax == int'(c_div) + 1, "R7", "half period",
          {32'(gmin), 32'(gmax)}, {32'(c_div + 1), 32'(c_div + 1)});
    check(spi_sclk == t_cpol, "R7", "sclk rest level", spi_sclk, t_cpol);
    check(tx_ready && sts_tx_empty, "R8", "empty after load", tx_ready, 1);
    if (pop) begin
      rx_ready = 1;
      @(negedge clk);
      rx_ready = 0;
      check(!rx_valid && !sts_rx_full, "R9", "rx_valid after pop", rx_valid, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=%0d exp=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] wa, wb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(sts_tx_empty && tx_ready && !sts_rx_full && !rx_valid, "R1", "flags in reset",
          {sts_tx_empty, sts_rx_full}, 2'b10);
    check(spi_cs_n == 1 && spi_sclk == 0 && sts_enabled == 0, "R1", "cs/sclk/enable in reset",
          {spi_cs_n, spi_sclk, sts_enabled}, 3'b100);
    rst_n = 1;
    @(negedge clk);

    // R2: disabled engine holds its word
    prep(0, 0, 0, 0, 2'd0, 3'd1);
    check(!sts_enabled, "R2", "readback while off", sts_enabled, 0);
    push(32'h0000_005A, 1);
    repeat (40) @(negedge clk);
    check(edges == 0 && !rx_valid, "R2", "no activity while off", edges, 0);
    check(!tx_ready, "R2", "word held while off", tx_ready, 0);
    ctl_enable = 1;
    @(negedge clk);
    check(sts_enabled, "R2", "readback after enable", sts_enabled, 1);
    finish(32'h0000_005A, 1);

    // R3: chip select level
    ctl_cs_level = 0;
    @(negedge clk);
    check(spi_cs_n == 0, "R3", "cs asserted", spi_cs_n, 0);
    ctl_cs_level = 1;
    @(negedge clk);
    check(spi_cs_n == 1, "R3", "cs released", spi_cs_n, 1);
    ctl_cs_level = 0;

    // directed corners: every mode, both orders, both widths, code 3, div 0 and max
    prep(0, 0, 0, 0, 2'd1, 3'd0); push(32'h1234_A5C3, 0); finish(32'h1234_A5C3, 1);
    prep(0, 1, 1, 1, 2'd1, 3'd2); push(32'h8001_7FFE, 0); finish(32'h8001_7FFE, 1);
    prep(1, 0, 1, 0, 2'd3, 3'd7); push(32'hDEAD_BEEF, 0); finish(32'hDEAD_BEEF, 1);
    prep(1, 1, 0, 1, 2'd0, 3'd0); push(32'hFFFF_0F0F, 0); finish(32'hFFFF_0F0F, 1);
    prep(0, 0, 1, 1, 2'd3, 3'd1); push(32'h0102_0304, 0); finish(32'h0102_0304, 1);

    // R10: unread receive word holds the next transmit word
    prep(0, 1, 0, 0, 2'd2, 3'd0);
    wa = $urandom;
    push(wa, 0);
    finish(wa, 0);
    wb = rx_data;
    prep(0, 1, 0, 0, 2'd2, 3'd0);
    push(32'hC0FF_EE11, 1);
    repeat (60) @(negedge clk);
    check(!tx_ready && edges == 0, "R10", "next word held", {tx_ready, 31'(edges)}, 0);
    check(rx_valid && rx_data == wb, "R10", "rx word kept", rx_data, wb);
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
    finish(32'hC0FF_EE11, 1);

    // constrained random
    for (int i = 0; i < 36; i++) begin
      logic [31:0] w;
      prep(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), DIV_W'($urandom));
      w = $urandom;
      push(w, 0);
      finish(w, 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule